// File: doc/BRIEF.md
# Page-Zero Single-Bit Operation Unit

This execution unit carries out the four single-bit instruction families of a small 8-bit controller: force a bit high, force a bit low, and branch on a bit that is either high or low. A fetch stage gives it the opcode, the page-zero address byte, the signed relative offset byte and the address of the instruction, along with a start strobe. The unit then works through a fixed number of cycles. During that time it reads the target byte over a byte-wide memory port. For a set or clear it writes the byte back with one bit changed. For a test it reports the tested bit as the new carry value and returns the address of the next instruction.

All timing is fixed and does not depend on the data. A set or clear takes 7 cycles and a test-and-branch takes 10. The read data on the memory port is valid in the cycle after the read request. The unit's results stay on its outputs until the next operation is accepted.

Top module: `bitop_unit`

## Requirements
- R1: An opcode is accepted only when its bits 7..5 are all zero. Bit 4 high selects a set/clear and bit 4 low selects a test-and-branch. Bits 3..1 give the bit number n. Bit 0 low means set (or branch if the bit is one), and bit 0 high means clear (or branch if the bit is zero).
- R2: A set writes back the byte it read with bit n forced to one and every other bit unchanged.
- R3: A clear writes back the byte it read with bit n forced to zero and every other bit unchanged.
- R4: A set or clear makes exactly one read and then exactly one write, both at the page-zero address given at start. The upper address bits are zero, and the address stays steady for the whole operation.
- R5: For a set or clear, busy_o is high for exactly 7 cycles after the start edge, and done_o is high in the 7th of those cycles only.
- R6: A test-and-branch keeps busy_o high for exactly 10 cycles, with done_o in the 10th. It makes exactly one read and no write.
- R7: At done of a test-and-branch, carry_we_o is high and carry_o equals the tested bit, whether or not the branch is taken. A set or clear never raises carry_we_o.
- R8: A branch is taken when the tested bit equals the polarity that the opcode selects. A taken branch gives next_pc_o = pc + 3 + sign-extended offset, modulo 4096.
- R9: A test-and-branch that is not taken gives next_pc_o = pc + 3 and branch_taken_o = 0. A set or clear gives next_pc_o = pc + 2.
- R10: A start with an opcode above 0x1F is ignored. busy_o stays low, the memory port is not used, and memory is unchanged.
- R11: A start strobe that arrives while the unit is busy is ignored. The running operation finishes with its own operands and its own timing.
- R12: After reset, busy_o, done_o, mem_req_o and carry_we_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe from the fetch stage |
| opcode_i | input | 8 | Instruction opcode |
| zp_addr_i | input | 8 | Page-zero address byte |
| rel_off_i | input | 8 | Signed branch offset byte |
| pc_i | input | 12 | Address of the instruction |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable (with request) |
| mem_addr_o | output | 12 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after a read request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last cycle of the operation |
| carry_we_o | output | 1 | Carry update strobe |
| carry_o | output | 1 | New carry value |
| branch_taken_o | output | 1 | Branch taken |
| next_pc_o | output | 12 | Address of the next instruction |

## Verification
The bench runs set and clear on bit 0, bit 7 and middle bits, including bytes where the bit already has the requested value. A design that decoded the bit number from the wrong opcode bits, or that touched neighbouring bits, would write a wrong byte. Branch targets are checked for a backward wrap below address zero and a forward wrap past 0xFFF, so an adder of the wrong width or without sign extension shows up. Carry is checked on branches that are not taken, which catches a design that updates carry only when the branch is taken. Finally, opcodes out of range and starts that arrive mid-operation must leave the memory traffic and the cycle counts unchanged.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    // Operation family chosen by opcode bit 4
    typedef enum logic {
        KIND_TEST   = 1'b0,
        KIND_SETCLR = 1'b1
    } op_kind_e;

    localparam int OPC_W    = 8;
    localparam int BITSEL_W = 3;
    localparam int OFF_W    = 8;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [OPC_W-1:0]    opcode_i,
    output logic                valid_o,
    output op_kind_e            kind_o,
    output logic                pol_o,
    output logic [BITSEL_W-1:0] bitn_o
);

    always_comb begin
        valid_o = (opcode_i[7:5] == 3'b000);
        kind_o  = opcode_i[4] ? KIND_SETCLR : KIND_TEST;
        pol_o   = opcode_i[0];
        bitn_o  = opcode_i[3:1];
    end

endmodule

// File: rtl/bitop_datapath.sv
module bitop_datapath
    import bitop_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  op_kind_e            kind_i,
    input  logic                pol_i,
    input  logic [BITSEL_W-1:0] bitn_i,
    input  logic [DW-1:0]       rbyte_i,
    input  logic [OFF_W-1:0]    off_i,
    input  logic [AW-1:0]       pc_i,
    output logic [DW-1:0]       wbyte_o,
    output logic                tested_o,
    output logic                taken_o,
    output logic [AW-1:0]       next_pc_o
);

    localparam int EXT_W = AW - OFF_W;

    logic [DW-1:0] mask;
    logic [AW-1:0] off_ext;
    logic [AW-1:0] pc_plus2;
    logic [AW-1:0] pc_plus3;
    logic [AW-1:0] target;

    always_comb begin
        mask     = '0;
        mask[bitn_i] = 1'b1;
        // pol low: force one, pol high: force zero
        wbyte_o  = pol_i ? (rbyte_i & ~mask) : (rbyte_i | mask);
        tested_o = rbyte_i[bitn_i];
        // pol low: branch on one, pol high: branch on zero
        taken_o  = (kind_i == KIND_TEST) && (tested_o != pol_i);
        off_ext  = {{EXT_W{off_i[OFF_W-1]}}, off_i};
        pc_plus2 = pc_i + AW'(2);
        pc_plus3 = pc_i + AW'(3);
        target   = pc_plus3 + off_ext;
        if (kind_i == KIND_SETCLR) begin
            next_pc_o = pc_plus2;
        end else if (taken_o) begin
            next_pc_o = target;
        end else begin
            next_pc_o = pc_plus3;
        end
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int AW         = 12,
    parameter int PAGE_W     = 8,
    parameter int DW         = 8,
    parameter int SETCLR_LEN = 7,
    parameter int TEST_LEN   = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [OPC_W-1:0]   opcode_i,
    input  logic [PAGE_W-1:0]  zp_addr_i,
    input  logic [OFF_W-1:0]   rel_off_i,
    input  logic [AW-1:0]      pc_i,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [AW-1:0]      mem_addr_o,
    output logic [DW-1:0]      mem_wdata_o,
    input  logic [DW-1:0]      mem_rdata_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               carry_we_o,
    output logic               carry_o,
    output logic               branch_taken_o,
    output logic [AW-1:0]      next_pc_o
);

    localparam int MAX_LEN = (TEST_LEN > SETCLR_LEN) ? TEST_LEN : SETCLR_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] RD_CNT   = CNT_W'(2);
    localparam logic [CNT_W-1:0] DATA_CNT = CNT_W'(3);
    localparam logic [CNT_W-1:0] SC_END   = CNT_W'(SETCLR_LEN);
    localparam logic [CNT_W-1:0] TB_END   = CNT_W'(TEST_LEN);
    localparam logic [CNT_W-1:0] WR_CNT   = CNT_W'(SETCLR_LEN - 1);

    typedef struct packed {
        logic                busy;
        logic [CNT_W-1:0]    cnt;
        op_kind_e            kind;
        logic                pol;
        logic [BITSEL_W-1:0] bitn;
        logic [PAGE_W-1:0]   addr;
        logic [OFF_W-1:0]    offs;
        logic [AW-1:0]       pc;
        logic [DW-1:0]       rbyte;
    } state_t;

    state_t state_q, state_d;

    logic                dec_valid;
    op_kind_e            dec_kind;
    logic                dec_pol;
    logic [BITSEL_W-1:0] dec_bitn;

    bitop_decode u_decode (
        .opcode_i (opcode_i),
        .valid_o  (dec_valid),
        .kind_o   (dec_kind),
        .pol_o    (dec_pol),
        .bitn_o   (dec_bitn)
    );

    logic [DW-1:0] new_byte;
    logic          tested_bit;
    logic          taken;
    logic [AW-1:0] pc_next;

    bitop_datapath #(
        .AW (AW),
        .DW (DW)
    ) u_datapath (
        .kind_i    (state_q.kind),
        .pol_i     (state_q.pol),
        .bitn_i    (state_q.bitn),
        .rbyte_i   (state_q.rbyte),
        .off_i     (state_q.offs),
        .pc_i      (state_q.pc),
        .wbyte_o   (new_byte),
        .tested_o  (tested_bit),
        .taken_o   (taken),
        .next_pc_o (pc_next)
    );

    logic [CNT_W-1:0] end_cnt;
    logic             last_cyc;

    always_comb begin
        end_cnt  = (state_q.kind == KIND_SETCLR) ? SC_END : TB_END;
        last_cyc = state_q.busy && (state_q.cnt == end_cnt);
    end

    // next-state
    always_comb begin
        state_d = state_q;
        if (!state_q.busy) begin
            if (start_i && dec_valid) begin
                state_d.busy = 1'b1;
                state_d.cnt  = CNT_W'(1);
                state_d.kind = dec_kind;
                state_d.pol  = dec_pol;
                state_d.bitn = dec_bitn;
                state_d.addr = zp_addr_i;
                state_d.offs = rel_off_i;
                state_d.pc   = pc_i;
            end
        end else begin
            if (state_q.cnt == DATA_CNT) begin
                state_d.rbyte = mem_rdata_i;
            end
            if (last_cyc) begin
                state_d.busy = 1'b0;
            end else begin
                state_d.cnt = state_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    logic rd_cyc;
    logic wr_cyc;

    always_comb begin
        rd_cyc         = state_q.busy && (state_q.cnt == RD_CNT);
        wr_cyc         = state_q.busy && (state_q.kind == KIND_SETCLR)
                         && (state_q.cnt == WR_CNT);
        mem_req_o      = rd_cyc || wr_cyc;
        mem_we_o       = wr_cyc;
        mem_addr_o     = {{(AW-PAGE_W){1'b0}}, state_q.addr};
        mem_wdata_o    = new_byte;
        busy_o         = state_q.busy;
        done_o         = last_cyc;
        carry_we_o     = last_cyc && (state_q.kind == KIND_TEST);
        carry_o        = tested_bit;
        branch_taken_o = taken;
        next_pc_o      = pc_next;
    end

    // Assertions

    // R5: the done cycle is the final busy cycle
    assert_done_ends_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !busy_o);

    // R10: out-of-range opcode never starts an operation
    assert_ignore_bad_opcode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i && (opcode_i[7:5] != 3'b000)) |=> !busy_o);

    // R4: address held for the whole operation
    assert_addr_steady_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));

    // R2: the write-back differs from the byte read in at most one bit
    assert_single_bit_change_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> ($countones(mem_wdata_o ^ state_q.rbyte) <= 1));

    // R7: carry strobe appears only together with done
    assert_carry_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        carry_we_o |-> done_o);

    // R6: a test never writes memory
    assert_test_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && (state_q.kind == KIND_TEST)) |-> !mem_we_o);

    // R11: a running operation keeps running while start pulses
    assert_busy_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o) |=> busy_o);

endmodule

// File: tb/bitop_unit_tb.sv
`timescale 1ns/1ps
module bitop_unit_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = 8'h00;
    logic [7:0]  zp_addr_i = 8'h00;
    logic [7:0]  rel_off_i = 8'h00;
    logic [11:0] pc_i = 12'h000;
    logic        mem_req_o, mem_we_o;
    logic [11:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i;
    logic        busy_o, done_o, carry_we_o, carry_o, branch_taken_o;
    logic [11:0] next_pc_o;

    always #4 clk_i = ~clk_i;

    bitop_unit dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .opcode_i(opcode_i),
        .zp_addr_i(zp_addr_i), .rel_off_i(rel_off_i), .pc_i(pc_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .carry_we_o(carry_we_o),
        .carry_o(carry_o), .branch_taken_o(branch_taken_o), .next_pc_o(next_pc_o)
    );

    // memory model, one process owns the array
    logic [7:0] mem [256];
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = 8'h00;
    logic [7:0] pre_data = 8'h00;
    int         rd_n = 0;
    int         wr_n = 0;
    logic       cnt_clr = 1'b0;
    logic       hi_addr_seen = 1'b0;

    always @(posedge clk_i) begin
        if (cnt_clr) begin
            rd_n <= 0;
            wr_n <= 0;
            hi_addr_seen <= 1'b0;
        end else if (mem_req_o) begin
            if (mem_addr_o[11:8] != 4'h0) hi_addr_seen <= 1'b1;
            if (mem_we_o) begin
                mem[mem_addr_o[7:0]] <= mem_wdata_o;
                wr_n <= wr_n + 1;
            end else begin
                mem_rdata_i <= mem[mem_addr_o[7:0]];
                rd_n <= rd_n + 1;
            end
        end
        if (pre_we) mem[pre_addr] <= pre_data;
    end

    int errors = 0;
    int checks = 0;

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk_i);
        pre_we = 1'b1; pre_addr = a; pre_data = v;
        @(negedge clk_i);
        pre_we = 1'b0;
    endtask

    // results captured by run_op
    int   cyc_n;
    int   busy_n;
    int   cwe_n;
    logic r_carry, r_taken;
    logic [11:0] r_pc;

    task automatic run_op(input logic [7:0] op, input logic [7:0] a,
                          input logic [7:0] off, input logic [11:0] pc,
                          input bit disturb);
        @(negedge clk_i);
        cnt_clr = 1'b1;
        @(negedge clk_i);
        cnt_clr = 1'b0;
        start_i = 1'b1; opcode_i = op; zp_addr_i = a; rel_off_i = off; pc_i = pc;
        @(negedge clk_i);
        start_i = 1'b0;
        cyc_n = 1; busy_n = busy_o ? 1 : 0; cwe_n = carry_we_o ? 1 : 0;
        while (!done_o && cyc_n < 40) begin
            if (disturb && cyc_n == 3) begin
                start_i = 1'b1; opcode_i = 8'h11; zp_addr_i = a + 8'h1;
                rel_off_i = 8'h55; pc_i = 12'h777;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk_i);
            cyc_n++;
            if (busy_o) busy_n++;
            if (carry_we_o) cwe_n++;
        end
        start_i = 1'b0;
        r_carry = carry_o; r_taken = branch_taken_o; r_pc = next_pc_o;
        @(negedge clk_i);
        check("R5 busy low after done", int'(busy_o), 0);
    endtask

    task automatic t_reset;
        check("R12 busy after reset", int'(busy_o), 0);
        check("R12 done after reset", int'(done_o), 0);
        check("R12 mem_req after reset", int'(mem_req_o), 0);
        check("R12 carry_we after reset", int'(carry_we_o), 0);
    endtask

    // R1/R2/R4/R5/R9: set bit n (opcode 0x10 + 2n)
    task automatic t_set(input int n, input logic [7:0] a, input logic [7:0] init);
        logic [7:0] expv;
        poke(a, init);
        expv = init | (8'h01 << n);
        run_op(8'h10 + 8'(2*n), a, 8'h00, 12'h3F0, 1'b0);
        check("R2 set result", int'(mem[a]), int'(expv));
        check("R5 set cycles", cyc_n, 7);
        check("R5 set busy cycles", busy_n, 7);
        check("R4 set reads", rd_n, 1);
        check("R4 set writes", wr_n, 1);
        check("R4 page zero address", int'(hi_addr_seen), 0);
        check("R7 set no carry strobe", cwe_n, 0);
        check("R9 set next pc", int'(r_pc), 12'h3F2);
    endtask

    // R1/R3: clear bit n (opcode 0x11 + 2n)
    task automatic t_clear(input int n, input logic [7:0] a, input logic [7:0] init);
        logic [7:0] expv;
        poke(a, init);
        expv = init & ~(8'h01 << n);
        run_op(8'h11 + 8'(2*n), a, 8'h00, 12'h100, 1'b0);
        check("R3 clear result", int'(mem[a]), int'(expv));
        check("R5 clear cycles", cyc_n, 7);
        check("R4 clear writes", wr_n, 1);
    endtask

    // R6/R7/R8/R9: test-and-branch; pol 0 branches on one, pol 1 on zero
    task automatic t_branch(input int n, input bit pol, input logic [7:0] a,
                            input logic [7:0] init, input logic [7:0] off,
                            input logic [11:0] pc);
        logic bitv, exp_taken;
        logic [11:0] exp_pc;
        poke(a, init);
        bitv = init[n];
        exp_taken = pol ? !bitv : bitv;
        exp_pc = exp_taken ? (pc + 12'd3 + {{4{off[7]}}, off}) : (pc + 12'd3);
        run_op(8'(2*n) + 8'(pol), a, off, pc, 1'b0);
        check("R6 test cycles", cyc_n, 10);
        check("R6 test busy cycles", busy_n, 10);
        check("R6 test reads", rd_n, 1);
        check("R6 test writes", wr_n, 0);
        check("R6 memory untouched", int'(mem[a]), int'(init));
        check("R7 carry strobe count", cwe_n, 1);
        check("R7 carry value", int'(r_carry), int'(bitv));
        check("R8 taken", int'(r_taken), int'(exp_taken));
        check("R8 R9 next pc", int'(r_pc), int'(exp_pc));
    endtask

    // R10: opcodes above 0x1F ignored
    task automatic t_bad_op(input logic [7:0] op);
        int busy_seen;
        poke(8'h40, 8'h5A);
        @(negedge clk_i);
        cnt_clr = 1'b1;
        @(negedge clk_i);
        cnt_clr = 1'b0;
        start_i = 1'b1; opcode_i = op; zp_addr_i = 8'h40;
        @(negedge clk_i);
        start_i = 1'b0;
        busy_seen = 0;
        for (int i = 0; i < 12; i++) begin
            if (busy_o || done_o) busy_seen++;
            @(negedge clk_i);
        end
        check("R10 no busy", busy_seen, 0);
        check("R10 no accesses", rd_n + wr_n, 0);
        check("R10 memory unchanged", int'(mem[8'h40]), 8'h5A);
    endtask

    // R11: start during busy ignored
    task automatic t_busy_start;
        poke(8'h22, 8'h00);
        poke(8'h23, 8'hFF);
        run_op(8'h1E, 8'h22, 8'h00, 12'h200, 1'b1); // set bit 7 at 0x22
        check("R11 original op result", int'(mem[8'h22]), 8'h80);
        check("R11 other byte untouched", int'(mem[8'h23]), 8'hFF);
        check("R11 cycles kept", cyc_n, 7);
        check("R11 writes", wr_n, 1);
        check("R11 own pc", int'(r_pc), 12'h202);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_set(0, 8'h10, 8'h00);
        t_set(7, 8'h11, 8'h7F);
        t_set(3, 8'h12, 8'h08);   // already set
        t_clear(0, 8'h13, 8'hFF);
        t_clear(5, 8'h14, 8'h3C);
        t_clear(6, 8'h15, 8'h00); // already clear
        t_branch(2, 1'b0, 8'h30, 8'h04, 8'h10, 12'h400); // taken forward
        t_branch(2, 1'b0, 8'h31, 8'hFB, 8'h10, 12'h400); // not taken, carry 0
        t_branch(4, 1'b1, 8'h32, 8'h00, 8'hF8, 12'h002); // taken, wraps below 0
        t_branch(7, 1'b1, 8'h33, 8'h80, 8'hF8, 12'h500); // not taken, carry 1
        t_branch(1, 1'b0, 8'h34, 8'h02, 8'h7F, 12'hFFE); // taken, wraps above top
        t_bad_op(8'h20);
        t_bad_op(8'hA6);
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule